// File: doc/BRIEF.md
# Switchable-Width Parallel ROM Read Controller

This block sits between a synchronous host and an external asynchronous parallel ROM. The ROM can be organised as 16-bit words or as 8-bit bytes. The host presents an address and holds a request until the block accepts it. The block then drives the ROM's chip-enable, output-enable, width-select and address pins, waits out the ROM's access times as counts of system clocks, and captures the data bus. It returns the result as a one-cycle valid pulse.

In byte organisation the ROM reuses its top data pin as the lowest address input. While a byte access is in flight, the controller turns that pin into an output and drives the byte address's bit 0 on it. It never samples that pin as data. Only the low eight data lines are kept in byte mode, and the result is zero-extended to 16 bits. After each access both enables are released. A float interval then passes before the next access may start, so the ROM's outputs have let go of the bus before the controller drives it again.

Top module: `prom_reader`

## Requirements
- R1: After reset, `req_ready` is high, `rom_ce_n` and `rom_oe_n` are high, `rsp_valid` is low, `rom_wide_o` is high (word organisation) and `rom_msb_oe` is low.
- R2: `req_ready` is high only while no access or float interval is in progress. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and both enables go low in the next cycle.
- R3: Both enables stay low for exactly ACC_CYC cycles. ACC_CYC is the largest of the address, chip-enable, output-enable and read-cycle times, each divided by the clock period and rounded up. Output enable is never low while chip enable is high.
- R4: `rsp_valid` is high for exactly one cycle, which is the first cycle with the enables high again. `rsp_data` then holds the bus value from the last enabled cycle.
- R5: When the request's `byte_mode` is 0, `rom_wide_o` is 1 and `rom_addr_o` equals `req_addr[21:0]`. `rom_msb_oe` is 0, and all 16 bits of `rom_dq_i` are returned.
- R6: When the request's `byte_mode` is 1, `rom_wide_o` is 0 and `rom_addr_o` equals `req_addr[22:1]`. `rom_msb_oe` is 1 and `rom_msb_o` equals `req_addr[0]`. The result is `{8'h00, rom_dq_i[7:0]}`, and bits 15:8 of the bus are ignored.
- R7: After the enables rise, chip enable stays high and `req_ready` stays low for FLT_CYC cycles. FLT_CYC is the float time divided by the clock period, rounded up, and at least 1.
- R8: `byte_mode` is sampled only when a request is accepted. A change during an access alters neither the pins nor the data of that access.
- R9: `rom_addr_o`, `rom_msb_o` and `rom_wide_o` stay unchanged in every cycle that the enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host read request, held until accepted |
| req_ready | output | 1 | Controller idle and able to accept |
| req_addr | input | 23 | Byte address (bit 0 used only in byte mode) or word address in bits 21:0 |
| byte_mode | input | 1 | 1 selects byte organisation, 0 selects word organisation |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_data | output | 16 | Read result, zero-extended in byte mode |
| rom_addr_o | output | 22 | ROM address pins |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_wide_o | output | 1 | ROM width select, 1 for word organisation |
| rom_dq_i | input | 16 | ROM data bus as received |
| rom_msb_o | output | 1 | Value driven on the shared top data pin in byte mode |
| rom_msb_oe | output | 1 | Output enable for the shared top data pin |

## Verification
The assertions check several properties on every cycle. They check the exact length of each enabled window and that output enable never runs without chip enable. They check that the result strobe is a single cycle aligned with the release of the enables, and that the pins stay stable while enabled. They also check the float gap after release and the zero upper byte of byte-mode results. Some behaviour depends on the contents of the ROM and on the host's timing, and only the bench scenarios can show it. This covers returning the correct word or byte for a given address, including the odd/even byte select carried on the shared pin. It also covers ignoring junk on the upper data lines, ignoring a mode change in mid-access, and accepting a request that is held through a float interval.

// File: rtl/prom_rd_pkg.sv
// Package: shared state encoding and clock-count helpers for the ROM reader.
// Assumes all times are whole nanoseconds and the clock period is non-zero.
package prom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_FLOAT  = 2'd2
    } rd_state_t;

    // Number of whole clocks that covers a time, rounded up.
    function automatic int unsigned clk_ceil(input int unsigned t_ns, input int unsigned per_ns);
        return (t_ns + per_ns - 1) / per_ns;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/prom_rd_timer.sv
// Module: phase timer for the ROM reader.
// Counts cycles from a restart. Raises expired once the count equals the
// supplied last value, and holds there until the next restart.
// Assumes last is stable while a phase runs.
module prom_rd_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] last,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    assign expired = (cnt_q == last);

    // Cycle counter: cleared on restart, saturating at the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/prom_rd_pinmux.sv
// Module: address and width pins for the ROM reader.
// On load, latches the organisation and the request address. It then splits
// the address onto the ROM address pins and, in byte mode, onto the shared
// top data pin. Assumes load is only raised when the ROM is disabled.
module prom_rd_pinmux #(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              byte_in,
    input  logic [ADDR_W:0]   addr_in,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              wide_sel,
    output logic              msb_out,
    output logic              msb_oe
);

    logic              byte_q;
    logic [ADDR_W:0]   addr_q;

    // Latch the mode and address of an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= 1'b0;
            addr_q <= '0;
        end else if (load) begin
            byte_q <= byte_in;
            addr_q <= addr_in;
        end
    end

    // Route the latched address onto the pins for the latched organisation.
    always_comb begin
        if (byte_q) begin
            rom_addr = addr_q[ADDR_W:1];
            msb_out  = addr_q[0];
        end else begin
            rom_addr = addr_q[ADDR_W-1:0];
            msb_out  = 1'b0;
        end
    end

    assign wide_sel = ~byte_q;
    assign msb_oe   = byte_q;

endmodule

// File: rtl/prom_rd_capture.sv
// Module: data capture for the ROM reader.
// On strobe, registers the bus, keeping only the low lane in byte mode and
// zero-filling the rest. Emits a one-cycle valid.
// Assumes the bus is settled in the strobe cycle.
module prom_rd_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              byte_sel,
    input  logic [DATA_W-1:0] dq_in,
    output logic              valid,
    output logic [DATA_W-1:0] data
);

    localparam int LANE_W = DATA_W / 2;

    logic [DATA_W-1:0] masked;

    // Per-bit lane selection: upper lane is dropped in byte mode.
    for (genvar g = 0; g < DATA_W; g++) begin : g_lane
        if (g < LANE_W) begin : g_low
            assign masked[g] = dq_in[g];
        end else begin : g_high
            assign masked[g] = dq_in[g] & ~byte_sel;
        end
    end

    // Register the result and pulse valid for the strobe cycle only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= strobe;
            if (strobe) begin
                data <= masked;
            end
        end
    end

endmodule

// File: rtl/prom_reader.sv
// Module: read controller for an asynchronous parallel ROM with selectable
// word or byte organisation. Accepts a held request, enables the ROM for a
// clock count covering every access time, captures the bus, then holds a
// float interval before the next access.
// Assumes req_addr and byte_mode are stable while req_valid waits.
module prom_reader
    import prom_rd_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_ADDR_NS     = 100,
    parameter int T_CE_NS       = 100,
    parameter int T_OE_NS       = 50,
    parameter int T_CYCLE_NS    = 100,
    parameter int T_FLOAT_NS    = 20,
    parameter int ADDR_W        = 22,
    parameter int DATA_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W:0]   req_addr,
    input  logic              byte_mode,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] rom_addr_o,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    output logic              rom_wide_o,
    input  logic [DATA_W-1:0] rom_dq_i,
    output logic              rom_msb_o,
    output logic              rom_msb_oe
);

    localparam int unsigned ACC_RAW = max_u(
        max_u(clk_ceil(T_ADDR_NS, CLK_PERIOD_NS), clk_ceil(T_CE_NS, CLK_PERIOD_NS)),
        max_u(clk_ceil(T_OE_NS, CLK_PERIOD_NS), clk_ceil(T_CYCLE_NS, CLK_PERIOD_NS)));
    localparam int unsigned ACC_CYC = max_u(ACC_RAW, 1);
    localparam int unsigned FLT_CYC = max_u(clk_ceil(T_FLOAT_NS, CLK_PERIOD_NS), 1);
    localparam int          CNT_W   = $clog2(max_u(ACC_CYC, FLT_CYC) + 1);
    localparam logic [CNT_W-1:0] ACC_LAST = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] FLT_LAST = CNT_W'(FLT_CYC - 1);

    rd_state_t        state_q;
    logic             accept;
    logic             phase_done;
    logic             access_end;
    logic             timer_restart;
    logic [CNT_W-1:0] timer_last;
    logic             byte_live;

    assign req_ready     = (state_q == ST_IDLE);
    assign accept        = req_ready & req_valid;
    assign access_end    = (state_q == ST_ACCESS) & phase_done;
    assign timer_restart = accept | access_end;
    assign timer_last    = (state_q == ST_ACCESS) ? ACC_LAST : FLT_LAST;
    assign byte_live     = ~rom_wide_o;

    // Sequencer: idle -> enabled access -> float -> idle, with enables registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            rom_ce_n <= 1'b1;
            rom_oe_n <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        state_q  <= ST_ACCESS;
                        rom_ce_n <= 1'b0;
                        rom_oe_n <= 1'b0;
                    end
                end
                ST_ACCESS: begin
                    if (phase_done) begin
                        state_q  <= ST_FLOAT;
                        rom_ce_n <= 1'b1;
                        rom_oe_n <= 1'b1;
                    end
                end
                ST_FLOAT: begin
                    if (phase_done) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: begin
                    state_q  <= ST_IDLE;
                    rom_ce_n <= 1'b1;
                    rom_oe_n <= 1'b1;
                end
            endcase
        end
    end

    prom_rd_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (timer_restart),
        .last    (timer_last),
        .expired (phase_done)
    );

    prom_rd_pinmux #(
        .ADDR_W (ADDR_W)
    ) u_pinmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .byte_in  (byte_mode),
        .addr_in  (req_addr),
        .rom_addr (rom_addr_o),
        .wide_sel (rom_wide_o),
        .msb_out  (rom_msb_o),
        .msb_oe   (rom_msb_oe)
    );

    prom_rd_capture #(
        .DATA_W (DATA_W)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (access_end),
        .byte_sel (byte_live),
        .dq_in    (rom_dq_i),
        .valid    (rsp_valid),
        .data     (rsp_data)
    );

    // Checker support: length of the current run of enabled cycles.
    logic [CNT_W:0] low_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run_q <= '0;
        end else if (!rom_ce_n) begin
            low_run_q <= low_run_q + 1'b1;
        end else begin
            low_run_q <= '0;
        end
    end

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (rom_ce_n && rom_oe_n));                                  // R2
    AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |-> !rom_ce_n);                                               // R3
    AST_ACCESS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_ce_n) |-> (low_run_q == (CNT_W+1)'(ACC_CYC)));                // R3
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);                                              // R4
    AST_VALID_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $rose(rom_ce_n));                                         // R4
    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rom_wide_o) |-> (rsp_data[DATA_W-1:DATA_W/2] == '0));    // R6
    AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_ce_n) |=> (rom_ce_n && !req_ready));                          // R7
    AST_PINS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_ce_n && $past(!rom_ce_n)) |->
            ($stable(rom_addr_o) && $stable(rom_msb_o) && $stable(rom_wide_o))); // R9

endmodule

// File: tb/prom_reader_tb.sv
// Bench: behavioural ROM and a cycle-level reference model, compared each clock.
module prom_reader_tb;

    localparam int CLK_NS   = 10;
    localparam int ACC_EXP  = 10;   // ceil(max(100,100,50,100)/10)
    localparam int FLT_EXP  = 2;    // ceil(20/10)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [22:0] req_addr = '0;
    logic        byte_mode = 1'b0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic [21:0] rom_addr_o;
    logic        rom_ce_n, rom_oe_n, rom_wide_o, rom_msb_o, rom_msb_oe;
    logic [15:0] rom_dq;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_NS/2) clk = ~clk;

    prom_reader u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .byte_mode(byte_mode), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rom_addr_o(rom_addr_o), .rom_ce_n(rom_ce_n),
        .rom_oe_n(rom_oe_n), .rom_wide_o(rom_wide_o), .rom_dq_i(rom_dq),
        .rom_msb_o(rom_msb_o), .rom_msb_oe(rom_msb_oe)
    );

    function automatic logic [15:0] word_at(input logic [21:0] a);
        logic [31:0] t;
        t = {10'd0, a} * 32'h9E3779B1 + 32'h1234;
        return t[31:16] ^ t[15:0];
    endfunction

    function automatic logic [7:0] byte_at(input logic [22:0] b);
        logic [15:0] w;
        w = word_at(b[22:1]);
        return b[0] ? w[15:8] : w[7:0];
    endfunction

    // Behavioural ROM: junk on the bus unless both enables are low.
    always_comb begin
        if (!rom_ce_n && !rom_oe_n) begin
            if (rom_wide_o) rom_dq = word_at(rom_addr_o);
            else            rom_dq = {8'hD5, byte_at({rom_addr_o, rom_msb_o})};
        end else begin
            rom_dq = 16'hC3A5;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model state.
    int          m_phase = 0;
    int          m_cnt = 0;
    logic [22:0] m_addr = '0;
    logic        m_byte = 1'b0;
    logic        m_valid = 1'b0;
    logic [15:0] m_data = '0;
    logic [23:0] pend_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_addr = '0; m_byte = 1'b0; m_valid = 1'b0;
        end else begin
            m_valid = 1'b0;
            case (m_phase)
                0: if (req_valid) begin
                    m_addr = req_addr; m_byte = byte_mode; m_phase = 1; m_cnt = 0;
                    pend_q.push_back({byte_mode, req_addr});
                end
                1: if (m_cnt == ACC_EXP-1) begin
                    m_data  = m_byte ? {8'h00, rom_dq[7:0]} : rom_dq;
                    m_valid = 1'b1; m_phase = 2; m_cnt = 0;
                end else m_cnt++;
                default: if (m_cnt == FLT_EXP-1) m_phase = 0; else m_cnt++;
            endcase
        end
    end

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [23:0] p;
            chk("R2/R7 req_ready", req_ready, m_phase == 0);
            chk("R3 rom_ce_n", rom_ce_n, m_phase != 1);
            chk("R3 rom_oe_n", rom_oe_n, m_phase != 1);
            chk("R4 rsp_valid", rsp_valid, m_valid);
            chk("R5/R8 rom_wide_o", rom_wide_o, !m_byte);
            chk("R6 rom_msb_oe", rom_msb_oe, m_byte);
            if (m_phase == 1) begin
                chk("R9 rom_addr_o", rom_addr_o, m_byte ? m_addr[22:1] : m_addr[21:0]);
                if (m_byte) chk("R6 rom_msb_o", rom_msb_o, m_addr[0]);
            end
            if (m_valid) begin
                chk("R4 rsp_data", rsp_data, m_data);
                if (pend_q.size() > 0) begin
                    p = pend_q.pop_front();
                    if (p[23]) chk("R6 byte content", rsp_data, {8'h00, byte_at(p[22:0])});
                    else       chk("R5 word content", rsp_data, word_at(p[21:0]));
                end
            end
        end
    end

    task automatic do_read(input logic [22:0] a, input logic bm);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; byte_mode = bm;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!req_ready || m_phase != 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 req_ready", req_ready, 1);
        chk("R1 rom_ce_n", rom_ce_n, 1);
        chk("R1 rom_oe_n", rom_oe_n, 1);
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 rom_wide_o", rom_wide_o, 1);
        chk("R1 rom_msb_oe", rom_msb_oe, 0);
        rst_n = 1'b1;

        // R5: word reads at corners and a pattern
        do_read(23'h000000, 1'b0); wait_idle();
        do_read(23'h3FFFFF, 1'b0); wait_idle();
        do_read(23'h12A5C3, 1'b0); wait_idle();
        // R6: byte reads, even/odd, top address
        do_read(23'h000000, 1'b1); wait_idle();
        do_read(23'h000001, 1'b1); wait_idle();
        do_read(23'h7FFFFF, 1'b1); wait_idle();
        do_read(23'h2AAAAA, 1'b1); wait_idle();
        // R2/R7: back-to-back, request held through the float interval
        do_read(23'h001234, 1'b0);
        do_read(23'h001235, 1'b1);
        do_read(23'h001236, 1'b0);
        wait_idle();
        // R8: mode flip mid-access ignored
        @(negedge clk);
        req_valid = 1'b1; req_addr = 23'h0055AB; byte_mode = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        byte_mode = 1'b0;
        wait_idle();
        // R8: new mode takes effect at the next access
        do_read(23'h0055AB, 1'b0); wait_idle();
        repeat (4) @(negedge clk);
        chk("R4 all responses returned", pend_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule